// File: doc/BRIEF.md
# Chip-Select Wait-State Terminator

This block ends the bus cycles issued to one chip-selected memory region. A one-clock start strobe opens a cycle of one beat, or of several beats when the burst flag is set. For each beat the block chooses between two ways to end it. If auto-acknowledge is enabled, a wait-state counter counts down and the block acknowledges the beat itself. An external acknowledge input can also end the beat, and it always can, whether auto-acknowledge is on or off.

Whichever of the two arrives first ends the beat. When auto-acknowledge is off, only the external acknowledge can end a beat. Between beats of a burst the block pulses an address-increment strobe. One clock after the final beat is acknowledged, it pulses cycle-done and returns to idle. The wait-state count and the auto-acknowledge enable are static configuration inputs.

Top module: `cs_wait_term`

## Requirements
- R1: With auto-acknowledge set and no external acknowledge, `beat_ack` is high in exactly the (W+1)-th clock of each beat, where W = `wait_cfg` (0..15). The first clock of the first beat is the clock after the edge that samples `start`.
- R2: With auto-acknowledge clear, `beat_ack` stays low until `ext_ack` is high, whatever `wait_cfg` holds.
- R3: When `ext_ack` is high in any clock of a beat in progress, `beat_ack` is high in that same clock and the beat ends there. This holds before, at, or after the point the internal countdown would reach.
- R4: A cycle started with `burst`=1 has `beat_cnt`+1 beats, and a cycle started with `burst`=0 has one beat. The wait count reloads at the start of every beat, so each beat gets the full programmed wait.
- R5: `addr_inc` is high together with `beat_ack` on every beat except the final one, and is low at all other times.
- R6: `cyc_done` is high for exactly one clock, the clock after the final beat's `beat_ack`. The block is idle from then on.
- R7: `ext_ack` is ignored while no cycle is in progress. It produces no `beat_ack`, no `addr_inc` and no `cyc_done`.
- R8: `start` is ignored while a cycle is in progress. The beats of the running cycle are unaffected.
- R9: After reset the block is idle, with `beat_ack`, `addr_inc` and `cyc_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Cycle-start strobe, accepted only when idle |
| burst | input | 1 | Cycle is a burst |
| beat_cnt | input | BEAT_W | Burst beats minus one |
| wait_cfg | input | WS_W | Wait states per beat |
| auto_ack | input | 1 | Enable the internal acknowledge |
| ext_ack | input | 1 | External transfer acknowledge |
| beat_ack | output | 1 | Current beat ends this clock |
| addr_inc | output | 1 | Advance the beat address |
| cyc_done | output | 1 | One-clock pulse after the final beat |

## Verification
The bench uses the default widths: a 4-bit wait field and a 2-bit beat count. This covers every wait value from 0 to 15 and every burst length from one to four beats, each with auto-acknowledge on and off. Each of these is combined with an external acknowledge that is absent, arrives first, arrives midway, arrives together with the internal one, or arrives one clock too late. That last case shows that the internal countdown ends the beat first.

// File: rtl/cs_wait_term.sv
module cs_wait_term #(
  parameter int WS_W   = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              burst,
  input  logic [BEAT_W-1:0] beat_cnt,
  input  logic [WS_W-1:0]   wait_cfg,
  input  logic              auto_ack,
  input  logic              ext_ack,
  output logic              beat_ack,
  output logic              addr_inc,
  output logic              cyc_done
);

  logic              busy;
  logic [WS_W-1:0]   cnt;
  logic [BEAT_W-1:0] left;
  logic              last;
  logic              int_hit;

  assign last     = (left == '0);
  assign int_hit  = auto_ack && (cnt == '0);
  assign beat_ack = busy && (ext_ack || int_hit);
  assign addr_inc = beat_ack && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      left     <= '0;
      cyc_done <= 1'b0;
    end else begin
      cyc_done <= beat_ack && last;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= wait_cfg;
          left <= burst ? beat_cnt : '0;
        end
      end else if (beat_ack) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          left <= left - 1'b1;
          cnt  <= wait_cfg;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_ack && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  p_no_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_ack && !ext_ack |-> !beat_ack);

  p_ext_ends_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ext_ack |-> beat_ack);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && beat_ack && !last |=> busy && cnt == $past(wait_cfg));

  p_inc_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |-> beat_ack && !last);

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && beat_ack && last |=> cyc_done && !busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !beat_ack && !addr_inc);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_ack |=> busy && $stable(left));

endmodule

// File: tb/sim_cs_wait_term.sv
module sim_cs_wait_term;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, burst = 1'b0, auto_ack = 1'b0, ext_ack = 1'b0;
  logic [1:0] beat_cnt = '0;
  logic [3:0] wait_cfg = '0;
  logic       beat_ack, addr_inc, cyc_done;
  int         nvec = 0, nbad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  cs_wait_term u0 (.clk, .rst_n, .start, .burst, .beat_cnt, .wait_cfg,
                   .auto_ack, .ext_ack, .beat_ack, .addr_inc, .cyc_done);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog: actual run %0d cycles expected finish", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual {ack,inc,done}=%b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #12;
    chk("R9", {beat_ack, addr_inc, cyc_done}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    chk("R9", {beat_ack, addr_inc, cyc_done}, 3'b000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ext_ack = (i < 3); #1;
      chk("R7", {beat_ack, addr_inc, cyc_done}, 3'b000);
    end
    for (int ws = 0; ws < 16; ws++)
      for (int aa = 0; aa < 2; aa++)
        for (int nb = 1; nb <= 4; nb++)
          for (int em = 0; em < 5; em++) begin
            int e, endc;
            bit inject;
            if (aa == 0 && em == 0) continue;
            e = (em == 0) ? 0 : (em == 1) ? 1 : (em == 2) ? ws / 2 + 1 :
                (em == 3) ? ws + 1 : ws + 2;
            endc = 1000;
            if (aa == 1) endc = ws + 1;
            if (e != 0 && e < endc) endc = e;
            inject = (ws >= 3) && (aa == 1) && (em == 0);
            @(negedge clk);
            wait_cfg = 4'(ws); auto_ack = aa[0]; burst = (nb > 1);
            beat_cnt = 2'(nb - 1); start = 1'b1; ext_ack = 1'b0;
            for (int b = 0; b < nb; b++)
              for (int c = 1; c <= endc; c++) begin
                @(negedge clk);
                start = inject && (c == 2);
                ext_ack = (e != 0) && (c == e);
                #1;
                if (aa == 1 && e != 0 && e >= ws + 1)
                  chk("R1/R3", {beat_ack, addr_inc, cyc_done},
                      {c == endc, (c == endc) && (b < nb - 1), 1'b0});
                else if (aa == 0)
                  chk("R2", {beat_ack, addr_inc, cyc_done},
                      {c == endc, (c == endc) && (b < nb - 1), 1'b0});
                else if (e != 0)
                  chk("R3", {beat_ack, addr_inc, cyc_done},
                      {c == endc, (c == endc) && (b < nb - 1), 1'b0});
                else if (inject)
                  chk("R8", {beat_ack, addr_inc, cyc_done},
                      {c == endc, (c == endc) && (b < nb - 1), 1'b0});
                else
                  chk("R4/R5", {beat_ack, addr_inc, cyc_done},
                      {c == endc, (c == endc) && (b < nb - 1), 1'b0});
              end
            @(negedge clk); start = 1'b0; ext_ack = 1'b0; #1;
            chk("R6", {beat_ack, addr_inc, cyc_done}, 3'b001);
            @(negedge clk); #1;
            chk("R6", {beat_ack, addr_inc, cyc_done}, 3'b000);
          end
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule